// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This block sits between a processor core and a data memory that is one word wide and byte-addressed. On every access request it adds a sign-extended 16-bit displacement to a base register value, then splits the sum into a word address and a byte offset. For stores it produces a byte-enable mask and write data with each byte placed in its memory lane. A byte store takes the lowest byte of the source register. A halfword store takes the lowest two bytes.

For loads the memory returns the addressed word one cycle after the read strobe. The unit keeps the byte offset, size and signedness of the request for that cycle. It then selects the addressed byte or halfword and sign- or zero-extends it to the full data width. Lanes are big-endian: the lowest address in a word holds its most significant byte.

A halfword access with an odd address, or a word access that is not on a word boundary, raises a misalignment flag. Such an access drives no strobes and no enables. Trap handling is left to the core.

Top module: `lsu_be_lane_unit`

## Requirements
- R1: The effective address is `base_i` plus `offset_i` sign-extended to 32 bits. `mem_addr_o` carries bits 31:2 of that sum.
- R2: `size_i` codes are 2'b00 byte, 2'b01 halfword, 2'b10 word and 2'b11 word. With `req_i` high, `misalign_o` is 1 in two cases: a halfword whose effective address bit 0 is 1, or a word whose effective address bits 1:0 are nonzero. A byte access is never misaligned. With `req_i` low, `misalign_o` is 0.
- R3: `mem_be_o` bit 3 is the lowest-address byte of the word. A byte at offset k enables bit 3-k. A halfword at offset 0 gives 4'b1100 and at offset 2 gives 4'b0011. A word gives 4'b1111. The mask is 4'b0000 when `req_i` is low or the access is misaligned.
- R4: `mem_wdata_o` places store data in lanes. A byte store puts `wdata_i[7:0]` at bits [31-8k -: 8]. A halfword store puts `wdata_i[15:0]` at bits 31:16 for offset 0 and at bits 15:0 for offset 2. A word store passes `wdata_i` through unchanged. Lanes that are not enabled are zero.
- R5: `mem_we_o` is 1 only for a requested, aligned access with `we_i` high. `mem_re_o` is 1 only for a requested, aligned access with `we_i` low.
- R6: `ld_valid_o` is 1 in the cycle after a cycle with `mem_re_o` high, and 0 otherwise. That includes the cycle after a store, after a misaligned access and after an idle cycle. `ld_data_o` is zero while `ld_valid_o` is 0.
- R7: A byte load returns the `mem_rdata_i` byte at bits [31-8k -: 8]. It is sign-extended when `unsigned_i` was 0 at request time and zero-extended when it was 1.
- R8: A halfword load returns bits 31:16 for offset 0 and bits 15:0 for offset 2. It is extended the same way as a byte load.
- R9: A word load returns `mem_rdata_i` unchanged, whatever the value of `unsigned_i`.
- R10: While `rst_ni` is low, `ld_valid_o` is 0 and `ld_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | Access size code |
| unsigned_i | input | 1 | 1 = zero-extend a byte or halfword load |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| wdata_i | input | 32 | Store source register |
| mem_addr_o | output | 30 | Word address |
| mem_be_o | output | 4 | Byte enables, bit 3 = lowest address |
| mem_wdata_o | output | 32 | Write data placed in lanes |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe |
| mem_rdata_i | input | 32 | Read word, valid the cycle after `mem_re_o` |
| ld_data_o | output | 32 | Extended load result |
| ld_valid_o | output | 1 | Load result valid |
| misalign_o | output | 1 | Misaligned access flag |

## Verification
Directed cases cover each byte offset at every size. They use data with the top bit set in the selected lane, so signed and unsigned extension give different results. They also use data whose bytes are all distinct, which shows a lane swap or a little-endian mapping.

Negative displacements and bases near the top of the address space check the sign extension and the carry of the address adder. Misaligned halfwords and words are interleaved with aligned accesses to show that the flag suppresses the strobes and the following load-valid pulse.

Size code 3 shows the word fallback. A long random mix of loads and stores, with sizes, offsets and signedness drawn at random, exercises the stored load context from one access to the next.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WRSV = 2'b11
  } lsu_size_e;

  typedef struct packed {
    logic [1:0] size;
    logic       uns;
  } lsu_ld_ctx_t;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int NB     = 4,
  localparam int LANE_W = $clog2(NB)
) (
  input  logic                     req_i,
  input  logic [1:0]               size_i,
  input  logic [ADDR_W-1:0]        base_i,
  input  logic [OFF_W-1:0]         offset_i,
  output logic [ADDR_W-LANE_W-1:0] word_addr_o,
  output logic [LANE_W-1:0]        lane_off_o,
  output logic                     misalign_o
);
  import lsu_pkg::*;

  logic [ADDR_W-1:0] ea;
  logic              bad;

  assign ea = base_i + {{(ADDR_W-OFF_W){offset_i[OFF_W-1]}}, offset_i};
  assign word_addr_o = ea[ADDR_W-1:LANE_W];
  assign lane_off_o  = ea[LANE_W-1:0];

  always_comb begin
    unique case (lsu_size_e'(size_i))
      SZ_BYTE: bad = 1'b0;
      SZ_HALF: bad = ea[0];
      default: bad = |ea[LANE_W-1:0];
    endcase
  end

  assign misalign_o = req_i & bad;
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane #(
  parameter int DATA_W = 32,
  localparam int NB     = DATA_W / 8,
  localparam int LANE_W = $clog2(NB)
) (
  input  logic              en_i,
  input  logic [1:0]        size_i,
  input  logic [LANE_W-1:0] off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NB-1:0]     be_o,
  output logic [DATA_W-1:0] wdata_o
);
  import lsu_pkg::*;

  logic is_byte, is_half, is_word;
  assign is_byte = lsu_size_e'(size_i) == SZ_BYTE;
  assign is_half = lsu_size_e'(size_i) == SZ_HALF;
  assign is_word = size_i[1];

  // k = byte offset inside the word; big-endian, so it lands at lane NB-1-k
  for (genvar k = 0; k < NB; k++) begin : g_lane
    localparam int BIT_LO = (NB - 1 - k) * 8;
    logic       sel;
    logic [7:0] d;

    always_comb begin
      sel = is_word
          | (is_byte && off_i == LANE_W'(k))
          | (is_half && off_i[LANE_W-1:1] == (LANE_W-1)'(k / 2));
      if (is_word)      d = wdata_i[BIT_LO +: 8];
      else if (is_half) d = ((k % 2) == 0) ? wdata_i[15:8] : wdata_i[7:0];
      else              d = wdata_i[7:0];
    end

    assign be_o[NB-1-k]          = en_i & sel;
    assign wdata_o[BIT_LO +: 8]  = (en_i & sel) ? d : 8'h00;
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
  parameter int DATA_W = 32,
  localparam int NB     = DATA_W / 8,
  localparam int LANE_W = $clog2(NB)
) (
  input  logic              valid_i,
  input  logic [1:0]        size_i,
  input  logic              uns_i,
  input  logic [LANE_W-1:0] off_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] data_o
);
  import lsu_pkg::*;

  logic [7:0]  lane_b [NB];
  logic [7:0]  byte_v;
  logic [15:0] half_v;
  logic [DATA_W-1:0] ext;

  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign lane_b[k] = rdata_i[(NB-1-k)*8 +: 8];
  end

  always_comb begin
    byte_v = lane_b[off_i];
    half_v = {lane_b[{off_i[LANE_W-1:1], 1'b0}], lane_b[{off_i[LANE_W-1:1], 1'b1}]};
    unique case (lsu_size_e'(size_i))
      SZ_BYTE: ext = {{(DATA_W-8){~uns_i & byte_v[7]}}, byte_v};
      SZ_HALF: ext = {{(DATA_W-16){~uns_i & half_v[15]}}, half_v};
      default: ext = rdata_i;
    endcase
  end

  assign data_o = valid_i ? ext : '0;
endmodule

// File: rtl/lsu_be_lane_unit.sv
module lsu_be_lane_unit #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int DATA_W = 32,
  localparam int NB     = DATA_W / 8,
  localparam int LANE_W = $clog2(NB)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     we_i,
  input  logic [1:0]               size_i,
  input  logic                     unsigned_i,
  input  logic [ADDR_W-1:0]        base_i,
  input  logic [OFF_W-1:0]         offset_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [ADDR_W-LANE_W-1:0] mem_addr_o,
  output logic [NB-1:0]            mem_be_o,
  output logic [DATA_W-1:0]        mem_wdata_o,
  output logic                     mem_we_o,
  output logic                     mem_re_o,
  input  logic [DATA_W-1:0]        mem_rdata_i,
  output logic [DATA_W-1:0]        ld_data_o,
  output logic                     ld_valid_o,
  output logic                     misalign_o
);
  import lsu_pkg::*;

  logic [LANE_W-1:0] lane_off;
  logic              acc_ok;
  lsu_ld_ctx_t       ctx_q;
  logic [LANE_W-1:0] off_q;
  logic              vld_q;

  lsu_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .NB(NB)) u_addr (
    .req_i      (req_i),
    .size_i     (size_i),
    .base_i     (base_i),
    .offset_i   (offset_i),
    .word_addr_o(mem_addr_o),
    .lane_off_o (lane_off),
    .misalign_o (misalign_o)
  );

  assign acc_ok   = req_i & ~misalign_o;
  assign mem_we_o = acc_ok & we_i;
  assign mem_re_o = acc_ok & ~we_i;

  lsu_store_lane #(.DATA_W(DATA_W)) u_st (
    .en_i   (acc_ok),
    .size_i (size_i),
    .off_i  (lane_off),
    .wdata_i(wdata_i),
    .be_o   (mem_be_o),
    .wdata_o(mem_wdata_o)
  );

  // load context held for the cycle in which the memory answers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      ctx_q <= '0;
      off_q <= '0;
    end else begin
      vld_q <= mem_re_o;
      if (mem_re_o) begin
        ctx_q <= '{size: size_i, uns: unsigned_i};
        off_q <= lane_off;
      end
    end
  end

  assign ld_valid_o = vld_q;

  lsu_load_extract #(.DATA_W(DATA_W)) u_ld (
    .valid_i(vld_q),
    .size_i (ctx_q.size),
    .uns_i  (ctx_q.uns),
    .off_i  (off_q),
    .rdata_i(mem_rdata_i),
    .data_o (ld_data_o)
  );
endmodule

// File: rtl/lsu_be_lane_unit_chk.sv
module lsu_be_lane_unit_chk #(
  parameter int DATA_W = 32,
  localparam int NB = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [1:0]        size_i,
  input logic [NB-1:0]     mem_be_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic              misalign_o,
  input logic              ld_valid_o,
  input logic [DATA_W-1:0] ld_data_o
);
  AST_MISALIGN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> (mem_be_o == '0 && !mem_we_o && !mem_re_o)); // R3

  AST_BYTE_NEVER_MISALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i == 2'b00) |-> !misalign_o); // R2

  AST_BYTE_ONE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i == 2'b00) |-> $countones(mem_be_o) == 1); // R3

  AST_HALF_TWO_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i == 2'b01 && !misalign_o) |-> $countones(mem_be_o) == 2); // R3

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o |-> (req_i && we_i)) and (mem_re_o |-> (req_i && !we_i))); // R5

  AST_READ_THEN_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> ld_valid_o); // R6

  AST_NO_READ_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_re_o |=> !ld_valid_o); // R6

  AST_DATA_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_valid_o |-> ld_data_o == '0); // R6
endmodule

bind lsu_be_lane_unit lsu_be_lane_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .size_i    (size_i),
  .mem_be_o  (mem_be_o),
  .mem_we_o  (mem_we_o),
  .mem_re_o  (mem_re_o),
  .misalign_o(misalign_o),
  .ld_valid_o(ld_valid_o),
  .ld_data_o (ld_data_o)
);

// File: tb/lsu_be_lane_unit_test.sv
`timescale 1ns/1ps
module lsu_be_lane_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, unsigned_i = 1'b0;
  logic [1:0]  size_i = 2'b00;
  logic [31:0] base_i = '0, wdata_i = '0, mem_rdata_i = '0;
  logic [15:0] offset_i = '0;
  logic [29:0] mem_addr_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_wdata_o, ld_data_o;
  logic        mem_we_o, mem_re_o, ld_valid_o, misalign_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  lsu_be_lane_unit uut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_mis(input logic [1:0] sz, input logic [1:0] o);
    if (sz == 2'b00) return 1'b0;
    if (sz == 2'b01) return o[0];
    return o != 2'b00;
  endfunction

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] o);
    case (sz)
      2'b00:   return 4'b1000 >> o;
      2'b01:   return o[1] ? 4'b0011 : 4'b1100;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] exp_wd(input logic [1:0] sz, input logic [1:0] o, input logic [31:0] d);
    case (sz)
      2'b00:   return {d[7:0], 24'h0} >> (8 * o);
      2'b01:   return o[1] ? {16'h0, d[15:0]} : {d[15:0], 16'h0};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] exp_ld(input logic [1:0] sz, input logic u, input logic [1:0] o, input logic [31:0] r);
    logic [31:0] s;
    s = r << (8 * o);
    case (sz)
      2'b00:   return u ? {24'h0, s[31:24]} : {{24{s[31]}}, s[31:24]};
      2'b01:   return u ? {16'h0, s[31:16]} : {{16{s[31]}}, s[31:16]};
      default: return r;
    endcase
  endfunction

  task automatic do_op(input logic w, input logic [1:0] sz, input logic u, input logic [31:0] b,
                       input logic [15:0] off, input logic [31:0] wd, input logic [31:0] rd);
    logic [31:0] ea;
    logic        mis;
    ea  = b + {{16{off[15]}}, off};
    mis = exp_mis(sz, ea[1:0]);
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; size_i = sz; unsigned_i = u;
    base_i = b; offset_i = off; wdata_i = wd;
    #1;
    check(mem_addr_o == ea[31:2], "R1 addr", {2'b0, mem_addr_o}, {2'b0, ea[31:2]});
    check(misalign_o == mis, "R2 misalign", {31'b0, misalign_o}, {31'b0, mis});
    check(mem_be_o == (mis ? 4'b0 : exp_be(sz, ea[1:0])), "R3 byte enables",
          {28'b0, mem_be_o}, {28'b0, mis ? 4'b0 : exp_be(sz, ea[1:0])});
    if (w && !mis)
      check(mem_wdata_o == exp_wd(sz, ea[1:0], wd), "R4 write data", mem_wdata_o, exp_wd(sz, ea[1:0], wd));
    check(mem_we_o == (w && !mis), "R5 we", {31'b0, mem_we_o}, {31'b0, w && !mis});
    check(mem_re_o == (!w && !mis), "R5 re", {31'b0, mem_re_o}, {31'b0, !w && !mis});
    @(negedge clk_i);
    req_i = 1'b0; mem_rdata_i = rd;
    #1;
    check(ld_valid_o == (!w && !mis), "R6 ld_valid", {31'b0, ld_valid_o}, {31'b0, !w && !mis});
    if (!w && !mis) begin
      if (sz == 2'b00)      check(ld_data_o == exp_ld(sz, u, ea[1:0], rd), "R7 byte load", ld_data_o, exp_ld(sz, u, ea[1:0], rd));
      else if (sz == 2'b01) check(ld_data_o == exp_ld(sz, u, ea[1:0], rd), "R8 half load", ld_data_o, exp_ld(sz, u, ea[1:0], rd));
      else                  check(ld_data_o == rd, "R9 word load", ld_data_o, rd);
    end else begin
      check(ld_data_o == 32'h0, "R6 idle data", ld_data_o, 32'h0);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    mem_rdata_i = 32'hFFFF_FFFF;
    #23;
    // R10: reset state
    check(ld_valid_o == 1'b0, "R10 reset valid", {31'b0, ld_valid_o}, 32'h0);
    check(ld_data_o == 32'h0, "R10 reset data", ld_data_o, 32'h0);
    check(misalign_o == 1'b0, "R2 idle misalign", {31'b0, misalign_o}, 32'h0);
    rst_ni = 1'b1;

    // R7: each byte offset, signed and unsigned, distinct byte values
    for (int o = 0; o < 4; o++) begin
      do_op(1'b0, 2'b00, 1'b0, 32'h0000_1000, 16'(o), 32'h0, 32'h80F1_7E92);
      do_op(1'b0, 2'b00, 1'b1, 32'h0000_1000, 16'(o), 32'h0, 32'h80F1_7E92);
      do_op(1'b1, 2'b00, 1'b0, 32'h0000_2000, 16'(o), 32'hCAFE_FACE, 32'h0);
    end
    // R8: halfword both aligned offsets; R2 odd offsets
    for (int o = 0; o < 4; o++) begin
      do_op(1'b0, 2'b01, 1'b0, 32'h0000_0008, 16'(o), 32'h0, 32'h8123_F456);
      do_op(1'b0, 2'b01, 1'b1, 32'h0000_0008, 16'(o), 32'h0, 32'h8123_F456);
      do_op(1'b1, 2'b01, 1'b0, 32'h0000_0008, 16'(o), 32'h1234_ABCD, 32'h0);
    end
    // R9 and R2: words, including size code 3 and misaligned offsets
    for (int o = 0; o < 4; o++) begin
      do_op(1'b0, 2'b10, 1'b0, 32'h0000_0100, 16'(o), 32'h0, 32'hDEAD_BEEF);
      do_op(1'b1, 2'b11, 1'b1, 32'h0000_0100, 16'(o), 32'h0BAD_F00D, 32'h0);
    end
    // R1: negative displacement and wrap at top of address space
    do_op(1'b0, 2'b10, 1'b0, 32'h0000_0010, 16'hFFFC, 32'h0, 32'h1357_9BDF);
    do_op(1'b1, 2'b00, 1'b0, 32'hFFFF_FFFE, 16'h0003, 32'h0000_00A5, 32'h0);
    do_op(1'b0, 2'b01, 1'b0, 32'h0000_0000, 16'h8000, 32'h0, 32'h7FFF_8000);

    for (int i = 0; i < 400; i++) begin
      do_op(1'($urandom), 2'($urandom), 1'($urandom), $urandom, 16'($urandom), $urandom, $urandom);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule